// File: doc/BRIEF.md
# Paired-Channel Trim Register Bank

This block holds the offset and gain trim bytes for two-channel converters. Software reaches it over a simple synchronous register bus that has an address, a write strobe, a read strobe, write data and registered read data. The trim values go straight out to the analog side as plain output ports. The bank serves two converter instances, and each instance has one offset pair and one gain pair. That makes four register pairs in total.

Each pair begins in a linked state. While a pair is linked, a write to the channel 0 register also lands in the channel 1 register. Calibration code written for a single channel therefore still trims both channels. The first direct write to the channel 1 register breaks the link for that pair only. After that, each channel of the pair is written on its own. The link stays broken until the next reset.

Top module: `trim_bank`

## Requirements
- R1: After reset every trim output is 0x00 and every pair is linked. A read of a status register returns 0x03.
- R2: While a pair is linked, a write to its channel 0 register stores the write data in both channel 0 and channel 1. Both outputs show the new value after that clock edge.
- R3: A write to a channel 1 register stores the data in channel 1 only. It leaves channel 0 unchanged and clears that pair's link flag on the same edge.
- R4: Once a pair is unlinked, a write to its channel 0 register changes channel 0 only. The pair stays unlinked through any later bus traffic until reset.
- R5: Each of the four pairs has its own link flag. The offset and gain pairs are independent, and so are the two instances: breaking one link leaves the other three pairs mirroring.
- R6: Instance k has base address 8*k, for k = 0 and 1. Its local offsets are 0 = channel 0 offset, 1 = channel 1 offset, 2 = channel 0 gain, 3 = channel 1 gain, and 4 = status. In the status register, bit 0 is 1 while the offset pair is linked and bit 1 is 1 while the gain pair is linked. The upper bits read as 0.
- R7: Read data is registered. It is valid on the cycle after the read strobe and holds until the next read strobe. It returns the value stored for the addressed channel.
- R8: A read of an unmapped address returns 0x00. Unmapped addresses are local offsets 5 to 7 and any address of instance 2 or above. A write to an unmapped address or to a status register changes no trim value and no link flag.
- R9: A reset after links have been broken restores every pair to the linked state, so channel 0 writes mirror again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| offset_ch0 | output | 16 | Channel 0 offset trim, instance k at bits [8k+7:8k] |
| offset_ch1 | output | 16 | Channel 1 offset trim, per instance |
| gain_ch0 | output | 16 | Channel 0 gain trim, per instance |
| gain_ch1 | output | 16 | Channel 1 gain trim, per instance |

## Verification
The bench checks the mirror on a linked channel 0 write, the link break on the first channel 1 write, and channel 0 writes after the break. A design that mirrored regardless of the link, or that cleared the wrong pair's flag, would show the wrong value on a channel 1 output. The bench breaks one pair while the other three stay linked; a single shared link flag would then stop mirroring on all four pairs. Writes to status and unmapped addresses, reads of unmapped space and a mid-run reset are also covered. A missing reset of the link flags would leave channel 0 writes unmirrored after reset, and a bad decode would alter a trim value or return nonzero read data.

// File: rtl/trim_pkg.sv
// Package: shared local-offset encoding for the paired trim bank.
// Assumes each instance occupies an 8-byte window of the register map.
package trim_pkg;
    localparam int LOC_W = 3;
    localparam logic [LOC_W-1:0] LOC_OFF0   = 3'd0;
    localparam logic [LOC_W-1:0] LOC_OFF1   = 3'd1;
    localparam logic [LOC_W-1:0] LOC_GAIN0  = 3'd2;
    localparam logic [LOC_W-1:0] LOC_GAIN1  = 3'd3;
    localparam logic [LOC_W-1:0] LOC_STATUS = 3'd4;

    typedef struct packed {
        logic wr0;
        logic wr1;
    } pair_wr_t;
endpackage

// File: rtl/trim_pair.sv
// Module: one linked pair of trim registers.
// A channel 0 write also lands in channel 1 while the link flag is set.
// A channel 1 write clears the flag, and only reset sets it again.
// Assumes that wr0 and wr1 are never both high, because the bus carries one address per cycle.
module trim_pair #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  trim_pkg::pair_wr_t wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ch0,
    output logic [DATA_W-1:0] ch1,
    output logic              linked
);
    // Channel 0 register: follows direct channel 0 writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch0 <= '0;
        end else if (wr.wr0) begin
            ch0 <= wdata;
        end
    end

    // Channel 1 register and link flag: a direct write wins and unlinks; otherwise mirror while linked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch1    <= '0;
            linked <= 1'b1;
        end else if (wr.wr1) begin
            ch1    <= wdata;
            linked <= 1'b0;
        end else if (wr.wr0 && linked) begin
            ch1    <= wdata;
        end
    end
endmodule

// File: rtl/trim_instance.sv
// Module: the offset pair and gain pair of one converter instance, with local decode.
// Assumes sel is high only when the bus address falls inside this instance's window.
// rd_val is the combinational read value for the local offset. It is zero for unmapped offsets.
module trim_instance #(
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel,
    input  logic                       we,
    input  logic [trim_pkg::LOC_W-1:0] loc,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          off0,
    output logic [DATA_W-1:0]          off1,
    output logic [DATA_W-1:0]          gain0,
    output logic [DATA_W-1:0]          gain1,
    output logic                       off_linked,
    output logic                       gain_linked,
    output logic [DATA_W-1:0]          rd_val
);
    import trim_pkg::*;

    pair_wr_t off_wr;
    pair_wr_t gain_wr;

    // Write decode: turn the local offset into per-register write strobes.
    always_comb begin
        off_wr.wr0  = sel && we && (loc == LOC_OFF0);
        off_wr.wr1  = sel && we && (loc == LOC_OFF1);
        gain_wr.wr0 = sel && we && (loc == LOC_GAIN0);
        gain_wr.wr1 = sel && we && (loc == LOC_GAIN1);
    end

    trim_pair #(.DATA_W(DATA_W)) u_off (
        .clk(clk), .rst_n(rst_n), .wr(off_wr), .wdata(wdata),
        .ch0(off0), .ch1(off1), .linked(off_linked)
    );

    trim_pair #(.DATA_W(DATA_W)) u_gain (
        .clk(clk), .rst_n(rst_n), .wr(gain_wr), .wdata(wdata),
        .ch0(gain0), .ch1(gain1), .linked(gain_linked)
    );

    // Read select: pick the stored per-channel value or the link status.
    always_comb begin
        rd_val = '0;
        unique case (loc)
            LOC_OFF0:   rd_val = off0;
            LOC_OFF1:   rd_val = off1;
            LOC_GAIN0:  rd_val = gain0;
            LOC_GAIN1:  rd_val = gain1;
            LOC_STATUS: rd_val = DATA_W'({gain_linked, off_linked});
            default:    rd_val = '0;
        endcase
    end
endmodule

// File: rtl/trim_read_port.sv
// Module: registered read data path.
// Latches the selected instance's read value on a read strobe and returns 0 when no instance is hit.
// Assumes inst_idx is in range whenever hit is high.
module trim_read_port #(
    parameter int DATA_W   = 8,
    parameter int NUM_INST = 2,
    localparam int IDX_W   = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       re,
    input  logic                       hit,
    input  logic [IDX_W-1:0]           inst_idx,
    input  logic [NUM_INST*DATA_W-1:0] rd_vals,
    output logic [DATA_W-1:0]          rdata
);
    logic [DATA_W-1:0] sel_val;

    // Instance select: choose the read value of the addressed instance.
    always_comb begin
        sel_val = '0;
        for (int k = 0; k < NUM_INST; k++) begin
            if (hit && (int'(inst_idx) == k)) sel_val = rd_vals[k*DATA_W +: DATA_W];
        end
    end

    // Read register: update on a strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= sel_val;
        end
    end
endmodule

// File: rtl/trim_bank.sv
// Module: top of the paired-channel trim register bank.
// Splits the bus address into an instance index and a local offset, and fans writes out
// to NUM_INST instances. Trims leave as flat vectors with instance k at [k*DATA_W +: DATA_W].
// Assumes a single-port bus: one access per cycle, synchronous active-low reset.
module trim_bank #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 5,
    parameter int NUM_INST = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic                       bus_re,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [NUM_INST*DATA_W-1:0] offset_ch0,
    output logic [NUM_INST*DATA_W-1:0] offset_ch1,
    output logic [NUM_INST*DATA_W-1:0] gain_ch0,
    output logic [NUM_INST*DATA_W-1:0] gain_ch1
);
    import trim_pkg::*;

    localparam int INST_W = ADDR_W - LOC_W;
    localparam int IDX_W  = (NUM_INST > 1) ? $clog2(NUM_INST) : 1;

    logic [LOC_W-1:0]           loc;
    logic [INST_W-1:0]          inst_field;
    logic                       hit;
    logic [NUM_INST*DATA_W-1:0] rd_vals;
    logic [NUM_INST-1:0]        off_link;
    logic [NUM_INST-1:0]        gain_link;

    // Address split: local offset in the low bits, instance number above.
    always_comb begin
        loc        = bus_addr[LOC_W-1:0];
        inst_field = bus_addr[ADDR_W-1:LOC_W];
        hit        = int'(inst_field) < NUM_INST;
    end

    for (genvar k = 0; k < NUM_INST; k++) begin : g_inst
        logic sel_k;
        // Instance hit: this window is addressed.
        always_comb sel_k = (int'(inst_field) == k);

        trim_instance #(.DATA_W(DATA_W)) u_inst (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (sel_k),
            .we         (bus_we),
            .loc        (loc),
            .wdata      (bus_wdata),
            .off0       (offset_ch0[k*DATA_W +: DATA_W]),
            .off1       (offset_ch1[k*DATA_W +: DATA_W]),
            .gain0      (gain_ch0[k*DATA_W +: DATA_W]),
            .gain1      (gain_ch1[k*DATA_W +: DATA_W]),
            .off_linked (off_link[k]),
            .gain_linked(gain_link[k]),
            .rd_val     (rd_vals[k*DATA_W +: DATA_W])
        );
    end

    trim_read_port #(.DATA_W(DATA_W), .NUM_INST(NUM_INST)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .re      (bus_re),
        .hit     (hit),
        .inst_idx(IDX_W'(inst_field)),
        .rd_vals (rd_vals),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/trim_bank_chk.sv
// Checker: temporal properties of the trim bank, attached to every trim_bank by bind.
// Observes the top's ports and its per-pair link flags.
module trim_bank_chk #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 5,
    parameter int NUM_INST = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_we,
    input logic                       bus_re,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [NUM_INST*DATA_W-1:0] offset_ch0,
    input logic [NUM_INST*DATA_W-1:0] offset_ch1,
    input logic [NUM_INST*DATA_W-1:0] gain_ch0,
    input logic [NUM_INST*DATA_W-1:0] gain_ch1,
    input logic [NUM_INST-1:0]        off_link,
    input logic [NUM_INST-1:0]        gain_link
);
    // R1: reset clears all trims and links all pairs
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (offset_ch0 == '0 && offset_ch1 == '0 && gain_ch0 == '0 &&
                    gain_ch1 == '0 && &off_link && &gain_link));

    // R8: unmapped local offsets read back as zero
    p_unmapped_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr[2:0] > 3'd4) |=> bus_rdata == '0);

    for (genvar k = 0; k < NUM_INST; k++) begin : g_chk
        localparam logic [ADDR_W-1:0] A_OFF0  = ADDR_W'(k*8 + 0);
        localparam logic [ADDR_W-1:0] A_OFF1  = ADDR_W'(k*8 + 1);
        localparam logic [ADDR_W-1:0] A_GAIN0 = ADDR_W'(k*8 + 2);
        localparam logic [ADDR_W-1:0] A_GAIN1 = ADDR_W'(k*8 + 3);

        // R2: a linked channel 0 write mirrors into channel 1
        p_off_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == A_OFF0 && off_link[k]) |=>
            offset_ch1[k*DATA_W +: DATA_W] == $past(bus_wdata));
        p_gain_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == A_GAIN0 && gain_link[k]) |=>
            gain_ch1[k*DATA_W +: DATA_W] == $past(bus_wdata));

        // R3: a channel 1 write leaves channel 0 alone and unlinks the pair
        p_off_ch1_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == A_OFF1) |=>
            ($stable(offset_ch0[k*DATA_W +: DATA_W]) && !off_link[k]));
        p_gain_ch1_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == A_GAIN1) |=>
            ($stable(gain_ch0[k*DATA_W +: DATA_W]) && !gain_link[k]));

        // R4: once unlinked, a channel 0 write leaves channel 1 alone and the link stays broken
        p_off_unlinked_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == A_OFF0 && !off_link[k]) |=>
            $stable(offset_ch1[k*DATA_W +: DATA_W]));
        p_off_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !off_link[k] |=> !off_link[k]);
        p_gain_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !gain_link[k] |=> !gain_link[k]);

        // R5: an offset channel 1 write does not touch the gain link
        p_link_indep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == A_OFF1) |=> $stable(gain_link[k]));
    end
endmodule

bind trim_bank trim_bank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_INST(NUM_INST)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .offset_ch0(offset_ch0),
    .offset_ch1(offset_ch1), .gain_ch0(gain_ch0), .gain_ch1(gain_ch1),
    .off_link(off_link), .gain_link(gain_link)
);

// File: tb/sim_trim_bank.sv
// Bench: behavioural reference model of the trim bank, compared on every clock.
module sim_trim_bank;
    localparam int DW = 8;
    localparam int AW = 5;
    localparam int NI = 2;
    localparam int WATCHDOG_CYCLES = 200000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic            bus_re = 1'b0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic [NI*DW-1:0] offset_ch0, offset_ch1, gain_ch0, gain_ch1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state, indexed [instance][reg]: 0=off0 1=off1 2=gain0 3=gain1
    int m_trim [NI][4];
    bit m_link [NI][2];   // [inst][0]=offset linked, [1]=gain linked
    bit cmp_en = 0;

    always #5 clk = ~clk;

    trim_bank #(.DATA_W(DW), .ADDR_W(AW), .NUM_INST(NI)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .offset_ch0(offset_ch0),
        .offset_ch1(offset_ch1), .gain_ch0(gain_ch0), .gain_ch1(gain_ch1)
    );

    function automatic void model_reset();
        for (int k = 0; k < NI; k++) begin
            for (int r = 0; r < 4; r++) m_trim[k][r] = 0;
            m_link[k][0] = 1;
            m_link[k][1] = 1;
        end
    endfunction

    function automatic int model_read(int a);
        int k = a / 8;
        int l = a % 8;
        if (k >= NI) return 0;
        if (l < 4) return m_trim[k][l];
        if (l == 4) return (m_link[k][1] ? 2 : 0) + (m_link[k][0] ? 1 : 0);
        return 0;
    endfunction

    function automatic void model_write(int a, int d);
        int k = a / 8;
        int l = a % 8;
        if (k >= NI || l > 3) return;
        if (l == 0 || l == 2) begin
            m_trim[k][l] = d;
            if (m_link[k][l/2]) m_trim[k][l+1] = d;
        end else begin
            m_trim[k][l] = d;
            m_link[k][l/2] = 0;
        end
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison of every trim output against the model (R2 R3 R4 R5 R8)
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            for (int k = 0; k < NI; k++) begin
                check("R2 R3 R4 R5 R8", $sformatf("off0[%0d]", k), int'(offset_ch0[k*DW +: DW]), m_trim[k][0]);
                check("R2 R3 R4 R5 R8", $sformatf("off1[%0d]", k), int'(offset_ch1[k*DW +: DW]), m_trim[k][1]);
                check("R2 R3 R4 R5 R8", $sformatf("gain0[%0d]", k), int'(gain_ch0[k*DW +: DW]), m_trim[k][2]);
                check("R2 R3 R4 R5 R8", $sformatf("gain1[%0d]", k), int'(gain_ch1[k*DW +: DW]), m_trim[k][3]);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        bus_re = 1'b0;
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_addr = AW'(a);
        bus_wdata = DW'(d);
        bus_we = 1'b1;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(string req, int a);
        int exp;
        @(negedge clk);
        bus_addr = AW'(a);
        bus_re = 1'b1;
        exp = model_read(a);
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
        check(req, $sformatf("read addr %0d", a), int'(bus_rdata), exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        model_reset();
        do_reset();
        cmp_en = 1;
        // R1: reset state
        for (int a = 0; a < 16; a++) rd("R1", a);
        // R2: linked mirror, offset and gain
        wr(0, 8'h5A);
        rd("R2", 1);
        wr(2, 8'h11);
        rd("R2", 3);
        // R3: channel 1 write breaks only the offset link
        wr(1, 8'h22);
        rd("R3", 4);
        rd("R3", 0);
        // R4: unlinked channel 0 write stays local; link stays broken
        wr(0, 8'h33);
        rd("R4", 1);
        wr(0, 8'h34);
        rd("R4", 4);
        // R5: gain of instance 0 and both pairs of instance 1 still mirror
        wr(2, 8'h44);
        rd("R5", 3);
        wr(8, 8'h77);
        rd("R5", 9);
        rd("R5", 12);
        wr(11, 8'h66);
        wr(10, 8'h55);
        rd("R5", 11);
        rd("R5", 12);
        wr(10, 8'h56);
        // R6: full map readback of both instances
        for (int a = 0; a < 16; a++) rd("R6", a);
        // R8: status and unmapped writes are ignored, unmapped reads give zero
        wr(4, 8'h00);
        wr(5, 8'hFF);
        wr(13, 8'hFF);
        wr(16, 8'hAA);
        wr(24, 8'hBB);
        rd("R8", 4);
        rd("R8", 5);
        rd("R8", 7);
        rd("R8", 16);
        rd("R8", 31);
        // R7: read data holds without a strobe
        rd("R7", 0);
        repeat (3) @(negedge clk);
        check("R7", "held rdata", int'(bus_rdata), model_read(0));
        // R9: reset restores linking
        do_reset();
        rd("R9", 4);
        wr(0, 8'h9C);
        rd("R9", 1);
        wr(10, 8'hC3);
        rd("R9", 11);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule